// File: doc/BRIEF.md
# Register File with Same-Cycle Write Visibility

This block holds the integer register set of a five-stage pipeline: thirty-two entries of thirty-two bits. There are two independent read ports and one write port. The decode stage drives the two read addresses and receives operand data combinationally. The write-back stage presents a destination address, a result word and a write-enable bit, and the write commits on the rising clock edge.

When write-back targets a register that decode is reading in the same cycle, the read returns the incoming value rather than the stale stored one. This matches a write in the first half of the cycle followed by a read in the second half, and it removes the overlap hazard between those two stages. The block does this with an address comparator on each read port, gated by the write enable, and uses a single clock edge. Register zero always reads as zero, and a write to it is discarded, including on the bypass path. All ports are plain control and data pins because the block has no stream traffic, so no valid/ready handshake applies.

Top module: `wbr_regfile`

## Requirements
- R1: After reset every register reads as zero on both ports.
- R2: With wr_en high at a rising edge and wr_addr nonzero, wr_data is stored in that register and appears on any read port addressing it after the edge.
- R3: A read port whose address equals a nonzero wr_addr while wr_en is high returns wr_data in the same cycle, before the edge.
- R4: Address 0 reads as zero on either port at all times, whether or not a write to address 0 is in progress.
- R5: A write with wr_en low changes no register and produces no bypass.
- R6: The two read ports are independent: each returns the content of its own address, and both may address the same register.
- R7: A write to one register leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset, clears all registers |
| rd_addr_a | input | 5 | Address of the first read port |
| rd_data_a | output | 32 | Data from the first read port (combinational) |
| rd_addr_b | input | 5 | Address of the second read port |
| rd_data_b | output | 32 | Data from the second read port (combinational) |
| wr_en | input | 1 | Write enable from write-back |
| wr_addr | input | 5 | Write destination address |
| wr_data | input | 32 | Write data |

## Verification
The bench uses several patterns. It writes distinct values to every register and reads them back through both ports, which distinguishes storage and address decode from each other. Same-cycle collisions are sampled before the edge on port A, port B and both ports together, and this shows that the bypass works and is not just ordinary storage. It issues writes to register zero and writes with the enable low, each read back both during the same cycle and afterwards, which shows that neither the discard nor the enable gating leaks through the bypass. It also overwrites one register and then checks its neighbours, which catches cross-register corruption.

// File: rtl/wbr_regfile_pkg.sv
package wbr_regfile_pkg;
  parameter int unsigned XLEN  = 32;
  parameter int unsigned NREGS = 32;
  localparam int unsigned AW   = $clog2(NREGS);
  typedef logic [XLEN-1:0] word_t;
  typedef logic [AW-1:0]   addr_t;
endpackage

// File: rtl/wbr_store.sv
module wbr_store
  import wbr_regfile_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  addr_t wa,
  input  word_t wd,
  output word_t q [NREGS]
);
  assign q[0] = '0;
  for (genvar i = 1; i < NREGS; i++) begin : g_reg
    word_t r;
    always_ff @(posedge clk) begin
      if (!rst_n)                              r <= '0;
      else if (we && (wa == addr_t'(i)))       r <= wd;
    end
    assign q[i] = r;
  end
endmodule

// File: rtl/wbr_read_port.sv
module wbr_read_port
  import wbr_regfile_pkg::*;
(
  input  word_t q [NREGS],
  input  addr_t ra,
  input  logic  we,
  input  addr_t wa,
  input  word_t wd,
  output word_t rd
);
  logic hit;
  assign hit = we && (wa == ra) && (ra != '0);
  always_comb begin
    if (hit) rd = wd;
    else     rd = q[ra];
  end
endmodule

// File: rtl/wbr_regfile.sv
module wbr_regfile
  import wbr_regfile_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  rd_addr_a,
  output logic [31:0] rd_data_a,
  input  logic [4:0]  rd_addr_b,
  output logic [31:0] rd_data_b,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data
);
  word_t q [NREGS];

  wbr_store u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .wa(wr_addr), .wd(wr_data), .q(q)
  );

  wbr_read_port u_port_a (
    .q(q), .ra(rd_addr_a), .we(wr_en), .wa(wr_addr), .wd(wr_data), .rd(rd_data_a)
  );

  wbr_read_port u_port_b (
    .q(q), .ra(rd_addr_b), .we(wr_en), .wa(wr_addr), .wd(wr_data), .rd(rd_data_b)
  );
endmodule

// File: rtl/wbr_regfile_chk.sv
module wbr_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  rd_addr_a,
  input logic [31:0] rd_data_a,
  input logic [4:0]  rd_addr_b,
  input logic [31:0] rd_data_b,
  input logic        wr_en,
  input logic [4:0]  wr_addr,
  input logic [31:0] wr_data
);
  // R4
  zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == 5'd0) |-> (rd_data_a == 32'd0));
  // R4
  zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == 5'd0) |-> (rd_data_b == 32'd0));
  // R3
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 5'd0 && rd_addr_a == wr_addr) |-> (rd_data_a == wr_data));
  // R3
  bypass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 5'd0 && rd_addr_b == wr_addr) |-> (rd_data_b == wr_data));
  // R2
  commit_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 5'd0 && rd_addr_a == wr_addr) ##1
    (rd_addr_a == $past(wr_addr) && !(wr_en && wr_addr == rd_addr_a))
    |-> (rd_data_a == $past(wr_data)));
  // R6
  same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));
endmodule

bind wbr_regfile wbr_regfile_chk u_chk (.*);

// File: tb/wbr_regfile_tb.sv
module wbr_regfile_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [4:0] rd_addr_a = 0, rd_addr_b = 0, wr_addr = 0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = 0;
  logic wr_en = 0;
  int total = 0, bad = 0;
  logic [31:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  wbr_regfile u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    if (a != 0) model[a] = d;
    wr_en = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'(31 - i); #1;
      chk("R1 a", rd_data_a, 32'd0);
      chk("R1 b", rd_data_b, 32'd0);
    end
  endtask

  task automatic t_fill();
    for (int i = 1; i < 32; i++) wr(5'(i), 32'hA500_0000 + 32'(i * 7));
    for (int i = 0; i < 32; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'((i + 5) % 32); #1;
      chk("R2 a", rd_data_a, model[i]);
      chk("R6 b", rd_data_b, model[(i + 5) % 32]);
    end
  endtask

  task automatic t_bypass();
    rd_addr_a = 5'd9; rd_addr_b = 5'd3;
    wr_en = 1; wr_addr = 5'd9; wr_data = 32'hDEAD_BEEF; #1;
    chk("R3 a", rd_data_a, 32'hDEAD_BEEF);
    chk("R3 b unaffected", rd_data_b, model[3]);
    rd_addr_b = 5'd9; #1;
    chk("R3 both", rd_data_b, 32'hDEAD_BEEF);
    tick(); model[9] = 32'hDEAD_BEEF; wr_en = 0; #1;
    chk("R2 after", rd_data_a, 32'hDEAD_BEEF);
    rd_addr_a = 5'd8; rd_addr_b = 5'd10; #1;
    chk("R7 lower", rd_data_a, model[8]);
    chk("R7 upper", rd_data_b, model[10]);
  endtask

  task automatic t_zero();
    rd_addr_a = 0; rd_addr_b = 0;
    wr_en = 1; wr_addr = 0; wr_data = 32'hFFFF_FFFF; #1;
    chk("R4 bypass a", rd_data_a, 32'd0);
    chk("R4 bypass b", rd_data_b, 32'd0);
    tick(); wr_en = 0; #1;
    chk("R4 stored", rd_data_a, 32'd0);
  endtask

  task automatic t_disabled();
    rd_addr_a = 5'd17;
    wr_en = 0; wr_addr = 5'd17; wr_data = 32'h1234_5678; #1;
    chk("R5 no bypass", rd_data_a, model[17]);
    tick(); #1;
    chk("R5 no store", rd_data_a, model[17]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 0;
    repeat (2) tick();
    rst_n = 1; #1;
    t_reset();
    t_fill();
    t_bypass();
    t_zero();
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule